// File: doc/BRIEF.md
# Multiplexed Five-Pin I/O Port with Alternate Functions

This block is a five-pin general purpose I/O port for a small controller. Software reaches it over a simple register bus, with writes taken at the clock edge and reads returned combinationally. Each pin has a direction bit and an output latch bit. A pin whose direction bit is 1 drives its latch value onto the pad. A pin whose direction bit is 0 is an input, and its level is sampled through a two-flop synchronizer.

Some pins are lent to neighbouring logic. Pin 0 can carry a memory-access strobe. Pins 1 and 2 feed two external interrupts, each with its own polarity. Pins 3 and 4 belong to timers X and Y. Each of these two pins is the timer's input or, in pulse output mode, the timer's output. While its timer is not driving it, the same pin can also raise a counter interrupt, with the polarity that the timer supplies. The timers, the memory expansion logic and the interrupt controller are outside this block and appear only as ports.

Two small state machines carry the behaviour. Each pin has an ownership selector with three states: OWN_INPUT (the pad is undriven), OWN_LATCH (the pad is driven from the latch) and OWN_PERIPH (the pad is driven by the strobe or a timer). The selector picks OWN_PERIPH when the pin's alternate function claims it. Otherwise the direction bit chooses between OWN_LATCH and OWN_INPUT. Each of the four interrupt sources has an edge tracker with two states, LVL_LOW and LVL_HIGH. The tracker moves from LVL_LOW to LVL_HIGH when the synchronized level is 1 (a rising transition), and back when the level is 0 (a falling transition). A transition that matches the selected polarity issues a one-cycle request. The request is registered, so it appears on the third clock edge after the pad changes.

Top module: `altfn_port`

## Requirements
- R1: After reset the direction, latch, control and enable registers are all 0, every `pad_oe` bit is 0, all four interrupt outputs are 0, and reads of addresses 1, 2 and 3 return 0.
- R2: A pin that no alternate function claims has `pad_oe` equal to its direction bit (address 1, bit i for pin i), and `pad_out` equal to its latch bit (address 0, bit i).
- R3: A read of address 0 returns in bit i the latch bit when direction bit i is 1, and otherwise the pad level after two clock edges of synchronization. Bits 7..5 read 0.
- R4: Pin 0 drives `mem_strobe` with `pad_oe[0]`=1 only when control bit 0 (address 2) is 1 and `cpu_mode` is 1 (memory expansion) or 2 (microprocessor). In modes 0 (single chip) and 3 (treated as single chip), pin 0 is an ordinary port pin.
- R5: While `tmr_x_outmode` is 1, pin 3 drives `tmr_x_out` with `pad_oe[3]`=1, whatever its latch and direction bits hold. Pin 4 behaves the same way with `tmr_y_outmode` and `tmr_y_out`.
- R6: `tmr_x_in` and `tmr_y_in` carry the synchronized levels of pads 3 and 4.
- R7: `irq_ext[k]` (k=0 for pin 1, k=1 for pin 2) pulses high for exactly one cycle per qualifying edge of the synchronized pad. The edge is rising when its polarity bit is 1 and falling when it is 0; polarity bits are address 2 bit 1 (k=0) and bit 2 (k=1). The pulse appears after the third clock edge following the pad change, and only while enable bit k of address 3 is 1.
- R8: `irq_cnt[0]` (pin 3) and `irq_cnt[1]` (pin 4) pulse like R7. Their polarity comes from `tmr_x_pol` and `tmr_y_pol` (1 = rising), and their enables are bits 2 and 3 of address 3. They never pulse while the matching timer output mode is 1.
- R9: Changing any polarity while the pad level is steady produces no interrupt pulse.
- R10: Address 2 holds the strobe select (bit 0) and the two external polarities (bits 1, 2). Address 3 holds the enables: bit 0 for external 0, bit 1 for external 1, bit 2 for counter 0 and bit 3 for counter 1. Bits outside these fields read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cpu_mode | input | 2 | Processor mode: 0 single chip, 1 memory expansion, 2 microprocessor |
| mem_strobe | input | 1 | Memory-access strobe from expansion logic |
| tmr_x_outmode | input | 1 | Timer X is in pulse output mode |
| tmr_x_out | input | 1 | Timer X output level |
| tmr_x_pol | input | 1 | Counter interrupt 0 polarity, 1 = rising |
| tmr_y_outmode | input | 1 | Timer Y is in pulse output mode |
| tmr_y_out | input | 1 | Timer Y output level |
| tmr_y_pol | input | 1 | Counter interrupt 1 polarity, 1 = rising |
| pad_in | input | 5 | Pad input levels |
| pad_out | output | 5 | Pad output values |
| pad_oe | output | 5 | Pad output enables |
| tmr_x_in | output | 1 | Synchronized pin 3 level for timer X |
| tmr_y_in | output | 1 | Synchronized pin 4 level for timer Y |
| irq_ext | output | 2 | External interrupt request pulses |
| irq_cnt | output | 2 | Counter interrupt request pulses |

## Verification
The pin mux is driven with random mixes of register contents, processor mode, timer output modes and pad levels. These mixes separate the three ownership states on every pin, and they also show whether a register read returns the latch or the synchronized pad.

Directed cases cover the remaining boundaries:
- Modes 0 and 3 are compared against modes 1 and 2 for the strobe pin.
- A timer output is tested with the direction bit at 0.
- The read is checked one edge and two edges after a pad change, which pins the synchronizer depth.

Interrupt tests apply rising and falling pad edges under each polarity and with each enable. The pulses are counted, which shows whether a pulse is single and whether it matches the selected edge. Further tests toggle the polarities with the pads held steady, and drive a counter pin while its timer owns the pad.

// File: rtl/altfn_pkg.sv
package altfn_pkg;
    localparam int PINS        = 5;
    localparam int PIN_STROBE  = 0;
    localparam int PIN_EXT0    = 1;
    localparam int PIN_EXT1    = 2;
    localparam int PIN_TMRX    = 3;
    localparam int PIN_TMRY    = 4;
    localparam int NIRQ        = 4;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_DIR  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_IEN  = 2'd3;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_EXPAND = 2'd1,
        MODE_MICRO  = 2'd2,
        MODE_RSVD   = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        OWN_INPUT  = 2'd0,
        OWN_LATCH  = 2'd1,
        OWN_PERIPH = 2'd2
    } pin_owner_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/altfn_regs.sv
module altfn_regs
    import altfn_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [1:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [PINS-1:0] pad_sync,
    output logic [DW-1:0]   bus_rdata,
    output logic [PINS-1:0] latch_q,
    output logic [PINS-1:0] dir_q,
    output logic            strobe_sel_q,
    output logic [1:0]      ext_pol_q,
    output logic [NIRQ-1:0] ien_q
);
    logic [PINS-1:0] data_view;
    logic            unused_wbits;

    assign unused_wbits = ^bus_wdata[DW-1:PINS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q      <= '0;
            dir_q        <= '0;
            strobe_sel_q <= 1'b0;
            ext_pol_q    <= '0;
            ien_q        <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                ADDR_DATA: latch_q <= bus_wdata[PINS-1:0];
                ADDR_DIR:  dir_q   <= bus_wdata[PINS-1:0];
                ADDR_CTRL: begin
                    strobe_sel_q <= bus_wdata[0];
                    ext_pol_q    <= bus_wdata[2:1];
                end
                ADDR_IEN:  ien_q   <= bus_wdata[NIRQ-1:0];
                default:   ;
            endcase
        end
    end

    // per-pin choice between latch and synchronized pad
    generate
        for (genvar p = 0; p < PINS; p++) begin : g_view
            assign data_view[p] = dir_q[p] ? latch_q[p] : pad_sync[p];
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_DATA: bus_rdata[PINS-1:0] = data_view;
            ADDR_DIR:  bus_rdata[PINS-1:0] = dir_q;
            ADDR_CTRL: bus_rdata[2:0]      = {ext_pol_q, strobe_sel_q};
            ADDR_IEN:  bus_rdata[NIRQ-1:0] = ien_q;
            default:   bus_rdata = '0;
        endcase
    end

    // written registers keep their value when no write is issued
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(dir_q) && $stable(ien_q) && $stable(latch_q)));
endmodule

// File: rtl/altfn_sync.sv
module altfn_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/altfn_edge.sv
module altfn_edge
    import altfn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    input  logic enable,
    input  logic block,
    output logic pulse
);
    lvl_state_e state_q, state_d;
    logic       hit;
    logic       pulse_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // transitions and edge qualification
    always_comb begin
        state_d = state_q;
        hit     = 1'b0;
        unique case (state_q)
            LVL_LOW: if (lvl) begin
                state_d = LVL_HIGH;
                hit     = rise_sel;
            end
            LVL_HIGH: if (!lvl) begin
                state_d = LVL_LOW;
                hit     = !rise_sel;
            end
            default: state_d = LVL_LOW;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= hit && enable && !block;
    end

    assign pulse = pulse_q;

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && (rise_sel == $past(rise_sel))) |=> !pulse_q);

    assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pulse_q);

    assert_no_false_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == $past(lvl)) |=> !pulse_q);

    assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> !pulse_q);
endmodule

// File: rtl/altfn_mux.sv
module altfn_mux
    import altfn_pkg::*;
(
    input  logic [PINS-1:0] latch_q,
    input  logic [PINS-1:0] dir_q,
    input  logic            strobe_sel,
    input  logic [1:0]      cpu_mode,
    input  logic            mem_strobe,
    input  logic            tmr_x_outmode,
    input  logic            tmr_x_out,
    input  logic            tmr_y_outmode,
    input  logic            tmr_y_out,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe
);
    cpu_mode_e mode;
    logic      strobe_active;

    assign mode = cpu_mode_e'(cpu_mode);

    always_comb begin
        unique case (mode)
            MODE_EXPAND, MODE_MICRO: strobe_active = strobe_sel;
            MODE_SINGLE, MODE_RSVD:  strobe_active = 1'b0;
            default:                 strobe_active = 1'b0;
        endcase
    end

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            pin_owner_e owner;
            logic       periph_on;
            logic       periph_val;

            if (p == PIN_STROBE) begin : g_strobe
                assign periph_on  = strobe_active;
                assign periph_val = mem_strobe;
            end else if (p == PIN_TMRX) begin : g_tx
                assign periph_on  = tmr_x_outmode;
                assign periph_val = tmr_x_out;
            end else if (p == PIN_TMRY) begin : g_ty
                assign periph_on  = tmr_y_outmode;
                assign periph_val = tmr_y_out;
            end else begin : g_plain
                assign periph_on  = 1'b0;
                assign periph_val = 1'b0;
            end

            // ownership selection
            always_comb begin
                if (periph_on)     owner = OWN_PERIPH;
                else if (dir_q[p]) owner = OWN_LATCH;
                else               owner = OWN_INPUT;
            end

            // pad drive per owner
            always_comb begin
                unique case (owner)
                    OWN_PERIPH: begin pad_oe[p] = 1'b1; pad_out[p] = periph_val; end
                    OWN_LATCH:  begin pad_oe[p] = 1'b1; pad_out[p] = latch_q[p]; end
                    OWN_INPUT:  begin pad_oe[p] = 1'b0; pad_out[p] = latch_q[p]; end
                    default:    begin pad_oe[p] = 1'b0; pad_out[p] = latch_q[p]; end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/altfn_port.sv
module altfn_port
    import altfn_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [1:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [1:0]      cpu_mode,
    input  logic            mem_strobe,
    input  logic            tmr_x_outmode,
    input  logic            tmr_x_out,
    input  logic            tmr_x_pol,
    input  logic            tmr_y_outmode,
    input  logic            tmr_y_out,
    input  logic            tmr_y_pol,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic            tmr_x_in,
    output logic            tmr_y_in,
    output logic [1:0]      irq_ext,
    output logic [1:0]      irq_cnt
);
    logic [PINS-1:0] pad_sync;
    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] dir_q;
    logic            strobe_sel_q;
    logic [1:0]      ext_pol_q;
    logic [NIRQ-1:0] ien_q;

    logic [NIRQ-1:0] src_lvl;
    logic [NIRQ-1:0] src_rise;
    logic [NIRQ-1:0] src_block;
    logic [NIRQ-1:0] irq_all;

    altfn_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (pad_in),
        .q (pad_sync)
    );

    altfn_regs #(.DW(DW)) u_regs (
        .clk (clk),
        .rst_n (rst_n),
        .bus_we (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata (bus_wdata),
        .pad_sync (pad_sync),
        .bus_rdata (bus_rdata),
        .latch_q (latch_q),
        .dir_q (dir_q),
        .strobe_sel_q (strobe_sel_q),
        .ext_pol_q (ext_pol_q),
        .ien_q (ien_q)
    );

    altfn_mux u_mux (
        .latch_q (latch_q),
        .dir_q (dir_q),
        .strobe_sel (strobe_sel_q),
        .cpu_mode (cpu_mode),
        .mem_strobe (mem_strobe),
        .tmr_x_outmode (tmr_x_outmode),
        .tmr_x_out (tmr_x_out),
        .tmr_y_outmode (tmr_y_outmode),
        .tmr_y_out (tmr_y_out),
        .pad_out (pad_out),
        .pad_oe (pad_oe)
    );

    assign tmr_x_in = pad_sync[PIN_TMRX];
    assign tmr_y_in = pad_sync[PIN_TMRY];

    // interrupt source table: 0,1 external; 2,3 counter
    assign src_lvl   = {pad_sync[PIN_TMRY], pad_sync[PIN_TMRX],
                        pad_sync[PIN_EXT1], pad_sync[PIN_EXT0]};
    assign src_rise  = {tmr_y_pol, tmr_x_pol, ext_pol_q};
    assign src_block = {tmr_y_outmode, tmr_x_outmode, 2'b00};

    generate
        for (genvar s = 0; s < NIRQ; s++) begin : g_irq
            altfn_edge u_edge (
                .clk (clk),
                .rst_n (rst_n),
                .lvl (src_lvl[s]),
                .rise_sel (src_rise[s]),
                .enable (ien_q[s]),
                .block (src_block[s]),
                .pulse (irq_all[s])
            );
        end
    endgenerate

    assign irq_ext = irq_all[1:0];
    assign irq_cnt = irq_all[3:2];

    assert_tmr_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_x_outmode |-> (pad_oe[PIN_TMRX] && (pad_out[PIN_TMRX] == tmr_x_out)));

    assert_input_undriven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_q[PIN_EXT0] && !dir_q[PIN_EXT1]) |-> !(pad_oe[PIN_EXT0] || pad_oe[PIN_EXT1]));

    assert_strobe_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mode == 2'd0 && !dir_q[PIN_STROBE]) |-> !pad_oe[PIN_STROBE]);

    assert_irq_onehot_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_x_outmode && tmr_y_outmode) |=> (irq_cnt == 2'b00));
endmodule

// File: tb/test_altfn_port.sv
`timescale 1ns/100ps
module test_altfn_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] cpu_mode = 2'd0;
    logic       mem_strobe = 1'b0;
    logic       tmr_x_outmode = 1'b0, tmr_x_out = 1'b0, tmr_x_pol = 1'b0;
    logic       tmr_y_outmode = 1'b0, tmr_y_out = 1'b0, tmr_y_pol = 1'b0;
    logic [4:0] pad_in = 5'd0;
    logic [4:0] pad_out, pad_oe;
    logic       tmr_x_in, tmr_y_in;
    logic [1:0] irq_ext, irq_cnt;
    logic [3:0] irq_all;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the registers
    logic [4:0] m_latch = '0, m_dir = '0;
    logic [2:0] m_ctrl = '0;
    logic [3:0] m_ien = '0;

    altfn_port i_altfn_port (
        .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .cpu_mode, .mem_strobe,
        .tmr_x_outmode, .tmr_x_out, .tmr_x_pol,
        .tmr_y_outmode, .tmr_y_out, .tmr_y_pol,
        .pad_in, .pad_out, .pad_oe, .tmr_x_in, .tmr_y_in, .irq_ext, .irq_cnt
    );

    assign irq_all = {irq_cnt, irq_ext};

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic strobe_on(input logic [1:0] md, input logic sel);
        return sel && (md == 2'd1 || md == 2'd2);
    endfunction

    function automatic logic [4:0] exp_oe();
        logic [4:0] r = m_dir;
        if (strobe_on(cpu_mode, m_ctrl[0])) r[0] = 1'b1;
        if (tmr_x_outmode) r[3] = 1'b1;
        if (tmr_y_outmode) r[4] = 1'b1;
        return r;
    endfunction

    function automatic logic [4:0] exp_out();
        logic [4:0] r = m_latch;
        if (strobe_on(cpu_mode, m_ctrl[0])) r[0] = mem_strobe;
        if (tmr_x_outmode) r[3] = tmr_x_out;
        if (tmr_y_outmode) r[4] = tmr_y_out;
        return r;
    endfunction

    function automatic logic [7:0] exp_data(input logic [4:0] pads);
        return {3'b000, (m_dir & m_latch) | (~m_dir & pads)};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        unique case (a)
            2'd0: m_latch = d[4:0];
            2'd1: m_dir   = d[4:0];
            2'd2: m_ctrl  = d[2:0];
            2'd3: m_ien   = d[3:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic count_irq(input int idx, input int cycles, output int n);
        n = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (irq_all[idx]) n++;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        int n;
        void'($urandom(32'd1234));
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1 reset state
        check("R1 pad_oe", pad_oe, 5'd0);
        check("R1 irq", irq_all, 4'd0);
        rd(2'd1, rv); check("R1 dir read", rv, 8'd0);
        rd(2'd2, rv); check("R1 ctrl read", rv, 8'd0);
        rd(2'd3, rv); check("R1 ien read", rv, 8'd0);

        // random mixes, interrupts left disabled
        for (int it = 0; it < 60; it++) begin
            logic [4:0] pads;
            wr(2'd0, 8'($urandom));
            wr(2'd1, 8'($urandom));
            wr(2'd2, 8'($urandom) & 8'hF9);
            cpu_mode      = 2'($urandom);
            mem_strobe    = 1'($urandom);
            tmr_x_outmode = 1'($urandom);
            tmr_x_out     = 1'($urandom);
            tmr_y_outmode = 1'($urandom);
            tmr_y_out     = 1'($urandom);
            pads          = 5'($urandom);
            pad_in        = pads;
            settle(3);
            check("R2 R4 R5 pad_oe", pad_oe, exp_oe());
            check("R2 R4 R5 pad_out", pad_out, exp_out());
            rd(2'd0, rv); check("R3 data read", rv, exp_data(pads));
            rd(2'd2, rv); check("R10 ctrl read", rv, {5'd0, m_ctrl});
            check("R6 timer inputs", {tmr_y_in, tmr_x_in}, {pads[4], pads[3]});
        end

        // R10 upper bits ignored
        wr(2'd3, 8'hF0);
        rd(2'd3, rv); check("R10 ien upper bits", rv, 8'd0);
        wr(2'd2, 8'hF8);
        rd(2'd2, rv); check("R10 ctrl upper bits", rv, 8'd0);

        // R4 strobe ownership per mode
        tmr_x_outmode = 0; tmr_y_outmode = 0;
        wr(2'd1, 8'h00); wr(2'd0, 8'h00); wr(2'd2, 8'h01);
        mem_strobe = 1'b1;
        for (int md = 0; md < 4; md++) begin
            cpu_mode = 2'(md);
            settle(1);
            check("R4 strobe oe by mode", pad_oe[0], (md == 1 || md == 2) ? 1'b1 : 1'b0);
            check("R4 strobe value by mode", pad_out[0], (md == 1 || md == 2) ? 1'b1 : 1'b0);
        end

        // R5 timer drive with direction 0 and latch 1
        wr(2'd0, 8'h18);
        tmr_x_outmode = 1; tmr_x_out = 0; tmr_y_outmode = 1; tmr_y_out = 0;
        settle(1);
        check("R5 timer override oe", pad_oe[4:3], 2'b11);
        check("R5 timer override value", pad_out[4:3], 2'b00);
        tmr_x_outmode = 0; tmr_y_outmode = 0;
        settle(1);
        check("R5 released", pad_oe[4:3], 2'b00);

        // R3 synchronizer depth
        wr(2'd1, 8'h00);
        pad_in = 5'h00; settle(4);
        @(negedge clk); pad_in = 5'h06;
        @(posedge clk); #1; rd(2'd0, rv); check("R3 one edge", rv, 8'h00);
        @(posedge clk); #1; rd(2'd0, rv); check("R3 two edges", rv, 8'h06);

        // R7 external interrupts
        pad_in = 5'h00; wr(2'd2, 8'h02); wr(2'd3, 8'h03); settle(4);
        @(negedge clk); pad_in[1] = 1'b1;
        repeat (3) @(posedge clk); #1;
        check("R7 latency third edge", irq_ext[0], 1'b1);
        @(posedge clk); #1;
        check("R7 one cycle", irq_ext[0], 1'b0);
        settle(3);
        @(negedge clk); pad_in[1] = 1'b0;
        count_irq(0, 8, n); check("R7 falling ignored when rising", n, 0);
        pad_in[2] = 1'b1; count_irq(1, 8, n); check("R7 ext1 rising ignored when falling", n, 0);
        pad_in[2] = 1'b0; count_irq(1, 8, n); check("R7 ext1 falling", n, 1);
        wr(2'd3, 8'h00); settle(2);
        pad_in[1] = 1'b1; count_irq(0, 8, n); check("R7 disabled", n, 0);

        // R9 polarity toggles with steady pads
        wr(2'd3, 8'h0F);
        pad_in = 5'h1E; settle(6);
        tmr_x_pol = 0; tmr_y_pol = 0;
        n = 0;
        for (int t = 0; t < 8; t++) begin
            int c;
            wr(2'd2, (t % 2) ? 8'h06 : 8'h00);
            tmr_x_pol = ~tmr_x_pol; tmr_y_pol = ~tmr_y_pol;
            @(negedge clk);
            for (int s = 0; s < 4; s++) if (irq_all[s]) n++;
            count_irq(0, 1, c); n += c;
        end
        check("R9 no pulse on polarity change", n, 0);

        // R8 counter interrupts
        wr(2'd3, 8'h0C);
        tmr_x_pol = 1; tmr_y_pol = 0;
        pad_in = 5'h10; settle(6);
        pad_in[3] = 1'b1; count_irq(2, 8, n); check("R8 cnt0 rising", n, 1);
        pad_in[4] = 1'b0; count_irq(3, 8, n); check("R8 cnt1 falling", n, 1);
        tmr_x_outmode = 1; settle(2);
        pad_in[3] = 1'b0; count_irq(2, 8, n); check("R8 cnt0 blocked falling", n, 0);
        pad_in[3] = 1'b1; count_irq(2, 8, n); check("R8 cnt0 blocked in output mode", n, 0);
        tmr_x_outmode = 0;
        wr(2'd3, 8'h00); settle(2);
        pad_in[4] = 1'b1; tmr_y_pol = 1; count_irq(3, 8, n); check("R8 cnt1 disabled", n, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule